// File: doc/BRIEF.md
# ECC Error Status and Capture Unit

This block sits inside a memory controller next to the read path. It receives one-cycle event pulses for four kinds of occurrence: an access whose address falls outside the installed memory, a correctable ECC error, an uncorrectable ECC error, and completion of DRAM initialization. Each pulse comes with the address, data and ECC syndrome of the access. The block keeps a sticky status word with separate "one event" and "more than one event" flags for each error class. It also captures the details of the first event in each class, and keeps the syndrome of the most recent ECC event.

Software reaches the block through a small word-wide register port. A write to the status word clears flags one bit at a time (write-one-to-clear). A mask word suppresses individual interrupt sources or all of them at once. Capture registers hold the offending address, and for the ECC classes the data, split into low and high words. The interrupt output is raised whenever a set status flag is not masked.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every status bit, the syndrome field, the mask word and every capture register read zero, and the interrupt is low.
- R2: The first out-of-range event sets status bit 0. Its address is then readable at register 2 (bits 31:0) and register 3 (bits 63:32).
- R3: An event of a class whose one-event bit is already set sets that class's multiple bit and leaves the captured address and data unchanged. The multiple bit is status bit 1 for out-of-range, 3 for correctable and 5 for uncorrectable.
- R4: The first correctable event sets status bit 2 and captures its address at registers 4/5 and its data at registers 6/7, each as a low word then a high word.
- R5: The first uncorrectable event sets status bit 4 and captures its address at registers 8/9 and its data at registers 10/11, kept apart from the correctable capture.
- R6: Status register bits 23:16 show the syndrome of the most recent correctable or uncorrectable event, including events that do not reload the captures.
- R7: An initialization-done pulse sets status bit 6.
- R8: A write to the status register (register 0) clears each of bits 6:0 whose written bit is 1 and leaves the others. Writing 0x7F clears all of them. An event in the same cycle as a clear keeps its bit set.
- R9: The mask word (register 1, bits 6:0) disables the interrupt source in the same position when the bit is 1. The interrupt is the OR of the status bits that are set and unmasked. Writing 0x7F silences all sources.
- R10: Once a class's one-event bit has been cleared, the next event of that class captures fresh address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_oor | input | 1 | Out-of-range access pulse |
| ev_ce | input | 1 | Correctable ECC error pulse |
| ev_ue | input | 1 | Uncorrectable ECC error pulse |
| ev_init | input | 1 | DRAM initialization done pulse |
| ev_addr | input | 64 | Address of the reported access |
| ev_data | input | 64 | Data of the reported access |
| ev_syn | input | 8 | ECC syndrome of the reported access |
| reg_addr | input | 4 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each event input is high for one cycle per reported access. They also assume that address, data and syndrome are valid in every cycle an event is high. The assertion on acknowledge-all further assumes that no event arrives in the cycle of the clearing write. The bench drives every event as a single-cycle pulse with its sideband set in the same cycle. It issues the full-clear writes in quiet cycles, and it tests the collision of an event with a clear as a separate case against the port values.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
   // status bit positions; neighbouring software decodes these
   localparam int ST_OOR_ONE   = 0;
   localparam int ST_OOR_MULTI = 1;
   localparam int ST_CE_ONE    = 2;
   localparam int ST_CE_MULTI  = 3;
   localparam int ST_UE_ONE    = 4;
   localparam int ST_UE_MULTI  = 5;
   localparam int ST_INIT      = 6;
   localparam int NSTAT        = 7;
   localparam int SYN_LSB      = 16;

   // register word indices
   localparam int RA_STATUS  = 0;
   localparam int RA_MASK    = 1;
   localparam int RA_OOR_AL  = 2;
   localparam int RA_OOR_AH  = 3;
   localparam int RA_CE_AL   = 4;
   localparam int RA_CE_AH   = 5;
   localparam int RA_CE_DL   = 6;
   localparam int RA_CE_DH   = 7;
   localparam int RA_UE_AL   = 8;
   localparam int RA_UE_AH   = 9;
   localparam int RA_UE_DL   = 10;
   localparam int RA_UE_DH   = 11;
   localparam int NREGS      = 12;
endpackage

// File: rtl/ecc_cap_class.sv
module ecc_cap_class #(
   parameter int AW       = 64,
   parameter int DW       = 64,
   parameter bit HAS_DATA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          clr_one_i,
   input  logic          clr_multi_i,
   output logic          one_o,
   output logic          multi_o,
   output logic [AW-1:0] cap_addr_o,
   output logic [DW-1:0] cap_data_o
);
   logic          one_q, multi_q;
   logic [AW-1:0] cap_addr_q;
   logic          first_ev;

   assign first_ev = ev_i && !one_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         one_q      <= 1'b0;
         multi_q    <= 1'b0;
         cap_addr_q <= '0;
      end else begin
         if (ev_i)           one_q <= 1'b1;
         else if (clr_one_i) one_q <= 1'b0;
         if (ev_i && one_q)    multi_q <= 1'b1;
         else if (clr_multi_i) multi_q <= 1'b0;
         if (first_ev) cap_addr_q <= addr_i;
      end
   end

   generate
      if (HAS_DATA) begin : g_data
         logic [DW-1:0] cap_data_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        cap_data_q <= '0;
            else if (first_ev) cap_data_q <= data_i;
         end
         assign cap_data_o = cap_data_q;
      end else begin : g_nodata
         logic unused_data;
         assign unused_data = ^data_i;
         assign cap_data_o  = '0;
      end
   endgenerate

   assign one_o      = one_q;
   assign multi_o    = multi_q;
   assign cap_addr_o = cap_addr_q;

   // R2 / R4 / R5: first event of the class loads the capture
   p_first_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      first_ev |=> (cap_addr_o == $past(addr_i)) && one_o);
   // R3: a repeat event keeps the capture and flags multiple
   p_hold_on_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i && one_q) |=> $stable(cap_addr_o) && $stable(cap_data_o) && multi_o);
endmodule

// File: rtl/ecc_cap_rdmux.sv
module ecc_cap_rdmux #(
   parameter int RW    = 32,
   parameter int NREGS = 12,
   parameter int IW    = 4
) (
   input  logic [NREGS-1:0][RW-1:0] words_i,
   input  logic [IW-1:0]            idx_i,
   output logic [RW-1:0]            rdata_o
);
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NREGS; i++)
         if (idx_i == IW'(i)) rdata_o = words_i[i];
   end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_cap_pkg::*;
#(
   parameter int AW = 64,
   parameter int DW = 64,
   parameter int SW = 8,
   parameter int RW = 32,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_oor,
   input  logic          ev_ce,
   input  logic          ev_ue,
   input  logic          ev_init,
   input  logic [AW-1:0] ev_addr,
   input  logic [DW-1:0] ev_data,
   input  logic [SW-1:0] ev_syn,
   input  logic [IW-1:0] reg_addr,
   input  logic          reg_we,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          irq
);
   localparam int HALF_A = AW / 2;
   localparam int HALF_D = DW / 2;

   generate
      if (AW != 2*RW || DW != 2*RW) begin : g_bad_width
         initial $error("capture widths must be two register words");
      end
      if (SW > 8 || RW < SYN_LSB + 8) begin : g_bad_syn
         initial $error("syndrome field does not fit the status word");
      end
      if ((1 << IW) < NREGS) begin : g_bad_idx
         initial $error("register index too narrow");
      end
   endgenerate

   logic             st_wr, mk_wr;
   logic [NSTAT-1:0] clr;
   logic [NSTAT-1:0] stat;
   logic [NSTAT-1:0] mask_q;
   logic [SW-1:0]    syn_q;
   logic             init_q;
   logic [AW-1:0]    oor_a, ce_a, ue_a;
   logic [DW-1:0]    oor_d, ce_d, ue_d;
   logic             unused_wbits;

   assign st_wr = reg_we && (reg_addr == IW'(RA_STATUS));
   assign mk_wr = reg_we && (reg_addr == IW'(RA_MASK));
   assign clr   = st_wr ? reg_wdata[NSTAT-1:0] : '0;
   assign unused_wbits = ^{reg_wdata[RW-1:NSTAT], oor_d};

   ecc_cap_class #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_oor (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_oor), .addr_i(ev_addr), .data_i(ev_data),
      .clr_one_i(clr[ST_OOR_ONE]), .clr_multi_i(clr[ST_OOR_MULTI]),
      .one_o(stat[ST_OOR_ONE]), .multi_o(stat[ST_OOR_MULTI]),
      .cap_addr_o(oor_a), .cap_data_o(oor_d));

   ecc_cap_class #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_ce (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_ce), .addr_i(ev_addr), .data_i(ev_data),
      .clr_one_i(clr[ST_CE_ONE]), .clr_multi_i(clr[ST_CE_MULTI]),
      .one_o(stat[ST_CE_ONE]), .multi_o(stat[ST_CE_MULTI]),
      .cap_addr_o(ce_a), .cap_data_o(ce_d));

   ecc_cap_class #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_ue (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_ue), .addr_i(ev_addr), .data_i(ev_data),
      .clr_one_i(clr[ST_UE_ONE]), .clr_multi_i(clr[ST_UE_MULTI]),
      .one_o(stat[ST_UE_ONE]), .multi_o(stat[ST_UE_MULTI]),
      .cap_addr_o(ue_a), .cap_data_o(ue_d));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         syn_q  <= '0;
         mask_q <= '0;
      end else begin
         if (ev_init)             init_q <= 1'b1;
         else if (clr[ST_INIT])   init_q <= 1'b0;
         if (ev_ce || ev_ue)      syn_q  <= ev_syn;
         if (mk_wr)               mask_q <= reg_wdata[NSTAT-1:0];
      end
   end
   assign stat[ST_INIT] = init_q;

   assign irq = |(stat & ~mask_q);

   logic [NREGS-1:0][RW-1:0] words;
   always_comb begin
      words = '0;
      words[RA_STATUS][NSTAT-1:0]          = stat;
      words[RA_STATUS][SYN_LSB +: SW]      = syn_q;
      words[RA_MASK][NSTAT-1:0]            = mask_q;
      words[RA_OOR_AL] = oor_a[HALF_A-1:0];
      words[RA_OOR_AH] = oor_a[AW-1:HALF_A];
      words[RA_CE_AL]  = ce_a[HALF_A-1:0];
      words[RA_CE_AH]  = ce_a[AW-1:HALF_A];
      words[RA_CE_DL]  = ce_d[HALF_D-1:0];
      words[RA_CE_DH]  = ce_d[DW-1:HALF_D];
      words[RA_UE_AL]  = ue_a[HALF_A-1:0];
      words[RA_UE_AH]  = ue_a[AW-1:HALF_A];
      words[RA_UE_DL]  = ue_d[HALF_D-1:0];
      words[RA_UE_DH]  = ue_d[DW-1:HALF_D];
   end

   ecc_cap_rdmux #(.RW(RW), .NREGS(NREGS), .IW(IW)) u_rd (
      .words_i(words), .idx_i(reg_addr), .rdata_o(reg_rdata));

   // R7: init pulse raises its flag
   p_init_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_init |=> stat[ST_INIT]);
   // R6: syndrome follows the latest ECC event
   p_syn_latest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_ce || ev_ue) |=> syn_q == $past(ev_syn));
   // R8: acknowledge-all in a quiet cycle empties the status
   p_ack_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && &reg_wdata[NSTAT-1:0] && !(ev_oor || ev_ce || ev_ue || ev_init))
      |=> stat == '0);
   // R9: a fully set mask keeps the interrupt low
   p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);
endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_oor = 0, ev_ce = 0, ev_ue = 0, ev_init = 0;
   logic [63:0] ev_addr = '0, ev_data = '0;
   logic [7:0]  ev_syn = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ecc_err_capture u0 (.clk(clk), .rst_n(rst_n), .ev_oor(ev_oor), .ev_ce(ev_ce),
      .ev_ue(ev_ue), .ev_init(ev_init), .ev_addr(ev_addr), .ev_data(ev_data),
      .ev_syn(ev_syn), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      reg_addr = 4'(a);
      #1 v = reg_rdata;
   endtask

   task automatic chk_reg(string tag, int a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a); reg_wdata = d; reg_we = 1;
      @(negedge clk);
      reg_we = 0; reg_wdata = '0;
   endtask

   // kind: 0 oor, 1 ce, 2 ue, 3 init
   task automatic pulse(int kind, logic [63:0] a, logic [63:0] d, logic [7:0] s);
      @(negedge clk);
      ev_addr = a; ev_data = d; ev_syn = s;
      ev_oor = (kind == 0); ev_ce = (kind == 1); ev_ue = (kind == 2); ev_init = (kind == 3);
      @(negedge clk);
      ev_oor = 0; ev_ce = 0; ev_ue = 0; ev_init = 0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 12; i++) chk_reg($sformatf("R1 reg%0d", i), i, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_oor;
      pulse(0, 64'h0000_1234_0000_0010, 64'h0, 8'h00);
      chk_reg("R2 status", 0, 32'h01);
      chk_reg("R2 addr lo", 2, 32'h0000_0010);
      chk_reg("R2 addr hi", 3, 32'h0000_1234);
      pulse(0, 64'hFFFF_0000_FFFF_0000, 64'h0, 8'h00);
      chk_reg("R3 oor multi", 0, 32'h03);
      chk_reg("R3 oor addr kept", 2, 32'h0000_0010);
      wr(0, 32'h7F);
      chk_reg("R8 ack all", 0, 32'h0);
   endtask

   task automatic t_ce;
      pulse(1, 64'hAAAA_0001_BBBB_0002, 64'h1101_0101_2202_0202, 8'hF4);
      chk_reg("R4 status+R6 syn", 0, 32'h00F4_0004);
      chk_reg("R4 addr lo", 4, 32'hBBBB_0002);
      chk_reg("R4 addr hi", 5, 32'hAAAA_0001);
      chk_reg("R4 data lo", 6, 32'h2202_0202);
      chk_reg("R4 data hi", 7, 32'h1101_0101);
      pulse(1, 64'h5, 64'h6, 8'h0B);
      chk_reg("R3 ce multi R6 syn", 0, 32'h000B_000C);
      chk_reg("R3 ce data kept", 6, 32'h2202_0202);
      chk_reg("R5 ue capture untouched", 8, 32'h0);
      // R8 partial clear: only the one-event bit
      wr(0, 32'h04);
      chk_reg("R8 partial", 0, 32'h000B_0008);
      pulse(1, 64'h77, 64'h88, 8'h31);
      chk_reg("R10 recapture addr", 4, 32'h77);
      chk_reg("R10 recapture data", 6, 32'h88);
      wr(0, 32'h7F);
   endtask

   task automatic t_ue;
      pulse(2, 64'hCAFE_0000_0000_0020, 64'hF101_0101_0000_0000, 8'h8A);
      chk_reg("R5 status", 0, 32'h008A_0010);
      chk_reg("R5 addr lo", 8, 32'h0000_0020);
      chk_reg("R5 addr hi", 9, 32'hCAFE_0000);
      chk_reg("R5 data lo", 10, 32'h0);
      chk_reg("R5 data hi", 11, 32'hF101_0101);
      chk_reg("R5 ce capture separate", 4, 32'h77);
      pulse(2, 64'h1, 64'h2, 8'h8A);
      chk_reg("R3 ue multi", 0, 32'h008A_0030);
      chk_reg("R3 ue addr kept", 8, 32'h0000_0020);
      wr(0, 32'h7F);
   endtask

   task automatic t_init_collide;
      pulse(3, 64'h0, 64'h0, 8'h0);
      chk_reg("R7 init bit", 0, 32'h008A_0040);
      // clear and new init event in same cycle: event wins
      @(negedge clk);
      reg_addr = 4'd0; reg_wdata = 32'h7F; reg_we = 1; ev_init = 1;
      @(negedge clk);
      reg_we = 0; reg_wdata = '0; ev_init = 0;
      chk_reg("R8 event beats clear", 0, 32'h008A_0040);
      wr(0, 32'h7F);
   endtask

   task automatic t_mask;
      wr(1, 32'h40);
      chk_reg("R9 mask readback", 1, 32'h40);
      pulse(3, 64'h0, 64'h0, 8'h0);
      #1 check("R9 masked init no irq", {31'b0, irq}, 32'h0);
      pulse(0, 64'h9, 64'h0, 8'h0);
      #1 check("R9 unmasked oor irq", {31'b0, irq}, 32'h1);
      wr(1, 32'h7F);
      #1 check("R9 all masked", {31'b0, irq}, 32'h0);
      wr(1, 32'h0);
      #1 check("R9 unmask", {31'b0, irq}, 32'h1);
      wr(0, 32'h7F);
      #1 check("R8 irq drops after ack", {31'b0, irq}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_oor();
      t_ce();
      t_ue();
      t_init_collide();
      t_mask();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule